// File: doc/BRIEF.md
# RTC update-cycle and divider controller

This block is the timing core of a CMOS-style real-time clock. A fixed-rate time-base tick advances a sub-second phase counter. Once per second the counter wraps, and that wrap is the update cycle. At the wrap the block pulses `sec_advance` so that the calendar logic steps its time. It also sets the update-ended flag, and it sets the alarm flag when the calendar's current time equals the alarm compare value.

The block owns three registers on a byte-wide bus: the control register, the mode register and the flag register.

- **Control register** (address 0): holds a three-bit divider field in bits 6:4. It also holds four general bits in bits 3:0, which are stored but have no function here. Bit 7 is a read-only update-in-progress (UIP) status bit.
- **Mode register** (address 1): holds a freeze bit in bit 7 that stops updates. Bits 6:0 are stored only.
- **Flag register** (address 2): holds the update-ended flag (UF) in bit 4 and the alarm flag (AF) in bit 5. All other bits read as 0.

The clock runs only when the divider field is 010 and the freeze bit is 0. A divider field with bits 6:5 at 11 holds the divider in reset. Leaving divider reset restarts the phase at its midpoint, so the first update arrives half a second later. Clearing the freeze bit restarts the phase at zero. Entering divider reset pulses `latch_time`, which tells the calendar logic to capture the current time. Leaving divider reset, or clearing the freeze bit, pulses `reload_time`, which tells the calendar logic to reload its time registers.

A four-state machine drives UIP:

- **COUNT**: running, outside the UIP window.
- **WINDOW**: running, inside the last `UIP_TICKS` ticks of the second.
- **STOPPED**: the freeze bit is set, or the divider field is neither 010 nor a reset code.
- **DIVRST**: the divider field selects reset.

Each state is re-evaluated every cycle from the register and phase values of the coming cycle. This gives the following named transitions:

- `enter_window` (COUNT to WINDOW): the phase reaches the window start.
- `update_done` (WINDOW to COUNT): the phase wraps.
- `freeze` (any state to STOPPED): the clock stops without a divider reset.
- `div_hold` (any state to DIVRST): the divider enters reset.
- `resume` (STOPPED or DIVRST to COUNT or WINDOW): the clock starts running again; the target depends on the phase.
- `hold_to_freeze` (DIVRST to STOPPED): the divider leaves reset but the clock is still not running.

UIP is high only in WINDOW.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After synchronous reset, the control register reads 0x20 (divider 010, UIP 0), the mode register reads 0x00 and the flag register reads 0x00. `uip`, `sec_advance`, `latch_time` and `reload_time` are all 0.
- R2: While running (divider 010 and freeze bit 0), `sec_advance` pulses for one cycle every `TICKS_PER_SEC` ticks. With a tick in every cycle, consecutive pulses are exactly `TICKS_PER_SEC` cycles apart.
- R3: While the freeze bit (mode bit 7) is 1, or the divider field is neither 010 nor a reset code, the phase does not advance. No `sec_advance` occurs and UF is not set.
- R4: `uip` is high during the final `UIP_TICKS` ticks of each second and falls in the same cycle that `sec_advance` rises.
- R5: `uip` is 0 whenever the freeze bit is 1 or the divider is in reset. Writing either condition while `uip` is high drops `uip` by the next cycle.
- R6: A control write with new bits 6:5 = 11 while the old divider field is 010 or below pulses `latch_time` for one cycle, and `uip` is 0 from then on.
- R7: A control write that leaves divider reset (old bits 6:5 = 11, new divider 010 or below) pulses `reload_time`. It also loads the phase to its midpoint, so the first `sec_advance` comes `TICKS_PER_SEC/2` ticks after the write.
- R8: A mode write that changes bit 7 from 1 to 0 while the divider field is 010 or below pulses `reload_time`. It also loads the phase to zero, so the next `sec_advance` comes `TICKS_PER_SEC` ticks after the write.
- R9: Control bit 7 is read-only. A control write stores bits 6:0 and leaves the read-back UIP value set by the block, whether it reads 0 or 1 at the time.
- R10: Each update sets UF (flag bit 4). If `time_now` equals `alarm_cmp` in the update cycle, it also sets AF (flag bit 5).
- R11: Reading the flag register returns the flags and clears UF and AF at that clock edge. If an update happens at the same edge, the new flags win.
- R12: The phase advances only on cycles where `tick` is 1. With `tick` high every second cycle, the update period doubles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick enable, one per phase step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags on the flag register) |
| addr | input | 2 | Register select: 0 control, 1 mode, 2 flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| time_now | input | 24 | Current calendar time from the calendar logic |
| alarm_cmp | input | 24 | Alarm compare value from the calendar logic |
| uip | output | 1 | Update in progress |
| sec_advance | output | 1 | One-cycle pulse after each update: step the calendar |
| latch_time | output | 1 | One-cycle pulse: capture the current time on divider hold |
| reload_time | output | 1 | One-cycle pulse: reload the time registers on restart |

## Verification
A phase counter that is off by one, or that restarts at the wrong point, shows up at the ports as a `sec_advance` interval or a release-to-update delay that differs from the exact cycle count. That delay is the full second after clearing the freeze bit and half a second after leaving divider reset. It becomes visible at the first pulse, within one second of ticks. A state machine stuck in or out of WINDOW shows up in the number of cycles `uip` stays high before each pulse, or as `uip` still high the cycle after a freeze or divider-reset write. Flag-register faults appear on the first read after an update, and the read that coincides with an update edge exposes a clear that wrongly takes priority.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_WINDOW  = 2'd1,
        ST_STOPPED = 2'd2,
        ST_DIVRST  = 2'd3
    } upd_state_t;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_MODE  = 2'd1;
    localparam logic [1:0] SEL_FLAGS = 2'd2;

    localparam logic [2:0] DIV_NORMAL = 3'b010;

    localparam int FREEZE_BIT = 7;
    localparam int UF_BIT     = 4;
    localparam int AF_BIT     = 5;

endpackage

// File: rtl/rtc_ctl_regs.sv
module rtc_ctl_regs
    import rtc_upd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       uip,
    input  logic       wrap,
    input  logic       alarm_match,
    output logic [7:0] rdata,
    output logic [2:0] div_q,
    output logic [2:0] div_d,
    output logic       freeze_q,
    output logic       freeze_d,
    output logic       uf_q,
    output logic       ev_enter,
    output logic       ev_release,
    output logic       ev_unfreeze
);

    logic [6:0] ctrl_q, ctrl_d;
    logic [7:0] mode_q, mode_d;
    logic       uf_d;
    logic       af_q, af_d;
    logic       wr_ctrl, wr_mode, rd_flags;
    logic       old_div_low, new_div_low;

    assign wr_ctrl  = wr_en && (addr == SEL_CTRL);
    assign wr_mode  = wr_en && (addr == SEL_MODE);
    assign rd_flags = rd_en && (addr == SEL_FLAGS);

    assign div_q    = ctrl_q[6:4];
    assign freeze_q = mode_q[FREEZE_BIT];

    assign old_div_low = (ctrl_q[6:4] <= DIV_NORMAL);
    assign new_div_low = (wdata[6:4] <= DIV_NORMAL);

    // divider hold / release and unfreeze events
    assign ev_enter    = wr_ctrl && (wdata[6:5] == 2'b11) && old_div_low;
    assign ev_release  = wr_ctrl && (ctrl_q[6:5] == 2'b11) && new_div_low;
    assign ev_unfreeze = wr_mode && mode_q[FREEZE_BIT] && !wdata[FREEZE_BIT]
                         && old_div_low;

    always_comb begin
        ctrl_d = ctrl_q;
        mode_d = mode_q;
        if (wr_ctrl) begin
            ctrl_d = wdata[6:0];
        end
        if (wr_mode) begin
            mode_d = wdata;
        end
    end

    assign div_d    = ctrl_d[6:4];
    assign freeze_d = mode_d[FREEZE_BIT];

    always_comb begin
        uf_d = uf_q;
        af_d = af_q;
        if (rd_flags) begin
            uf_d = 1'b0;
            af_d = 1'b0;
        end
        if (wrap) begin
            uf_d = 1'b1;
            if (alarm_match) begin
                af_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= {DIV_NORMAL, 4'b0000};
            mode_q <= 8'h00;
            uf_q   <= 1'b0;
            af_q   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            mode_q <= mode_d;
            uf_q   <= uf_d;
            af_q   <= af_d;
        end
    end

    always_comb begin
        unique case (addr)
            SEL_CTRL:  rdata = {uip, ctrl_q};
            SEL_MODE:  rdata = mode_q;
            SEL_FLAGS: rdata = {2'b00, af_q, uf_q, 4'b0000};
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_phase_ctr.sv
module rtc_phase_ctr #(
    parameter int TICKS_PER_SEC = 1000000,
    parameter int UIP_TICKS     = 244
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run_q,
    input  logic load_zero,
    input  logic load_half,
    output logic wrap,
    output logic win_d
);

    localparam int PHASE_W = $clog2(TICKS_PER_SEC);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(TICKS_PER_SEC - 1);
    localparam logic [PHASE_W-1:0] HALF_PHASE = PHASE_W'(TICKS_PER_SEC / 2);
    localparam logic [PHASE_W-1:0] WIN_START  = PHASE_W'(TICKS_PER_SEC - UIP_TICKS);

    logic [PHASE_W-1:0] phase_q, phase_d;
    logic               step;

    assign step = tick && run_q && !load_zero && !load_half;
    assign wrap = step && (phase_q == LAST_PHASE);

    always_comb begin
        phase_d = phase_q;
        if (load_zero) begin
            phase_d = '0;
        end else if (load_half) begin
            phase_d = HALF_PHASE;
        end else if (step) begin
            phase_d = (phase_q == LAST_PHASE) ? '0 : phase_q + 1'b1;
        end
    end

    generate
        if (UIP_TICKS > 0) begin : g_window
            assign win_d = (phase_d >= WIN_START);
        end else begin : g_nowindow
            assign win_d = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

endmodule

// File: rtl/rtc_upd_fsm.sv
module rtc_upd_fsm
    import rtc_upd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic div_rst_d,
    input  logic run_d,
    input  logic win_d,
    input  logic wrap,
    input  logic ev_enter,
    input  logic ev_reload,
    output logic uip,
    output logic sec_advance,
    output logic latch_time,
    output logic reload_time
);

    upd_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_COUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT: begin
                if (div_rst_d)   state_d = ST_DIVRST;
                else if (!run_d) state_d = ST_STOPPED;
                else if (win_d)  state_d = ST_WINDOW;
            end
            ST_WINDOW: begin
                if (div_rst_d)   state_d = ST_DIVRST;
                else if (!run_d) state_d = ST_STOPPED;
                else if (!win_d) state_d = ST_COUNT;
            end
            ST_STOPPED: begin
                if (div_rst_d)  state_d = ST_DIVRST;
                else if (run_d) state_d = win_d ? ST_WINDOW : ST_COUNT;
            end
            ST_DIVRST: begin
                if (!div_rst_d) begin
                    if (!run_d)     state_d = ST_STOPPED;
                    else if (win_d) state_d = ST_WINDOW;
                    else            state_d = ST_COUNT;
                end
            end
        endcase
    end

    assign uip = (state_q == ST_WINDOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_advance <= 1'b0;
            latch_time  <= 1'b0;
            reload_time <= 1'b0;
        end else begin
            sec_advance <= wrap;
            latch_time  <= ev_enter;
            reload_time <= ev_reload;
        end
    end

endmodule

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl
    import rtc_upd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 1000000,
    parameter int UIP_TICKS     = 244,
    parameter int TIME_W        = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] alarm_cmp,
    output logic              uip,
    output logic              sec_advance,
    output logic              latch_time,
    output logic              reload_time
);

    logic [2:0] div_q, div_d;
    logic       freeze_q, freeze_d;
    logic       uf_q;
    logic       ev_enter, ev_release, ev_unfreeze;
    logic       run_q, run_d, div_rst_d;
    logic       wrap, win_d, alarm_match;

    assign alarm_match = (time_now == alarm_cmp);
    assign run_q       = (div_q == DIV_NORMAL) && !freeze_q;
    assign run_d       = (div_d == DIV_NORMAL) && !freeze_d;
    assign div_rst_d   = (div_d[2:1] == 2'b11);

    rtc_ctl_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .uip         (uip),
        .wrap        (wrap),
        .alarm_match (alarm_match),
        .rdata       (rdata),
        .div_q       (div_q),
        .div_d       (div_d),
        .freeze_q    (freeze_q),
        .freeze_d    (freeze_d),
        .uf_q        (uf_q),
        .ev_enter    (ev_enter),
        .ev_release  (ev_release),
        .ev_unfreeze (ev_unfreeze)
    );

    rtc_phase_ctr #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .UIP_TICKS     (UIP_TICKS)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run_q     (run_q),
        .load_zero (ev_unfreeze),
        .load_half (ev_release),
        .wrap      (wrap),
        .win_d     (win_d)
    );

    rtc_upd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .div_rst_d   (div_rst_d),
        .run_d       (run_d),
        .win_d       (win_d),
        .wrap        (wrap),
        .ev_enter    (ev_enter),
        .ev_reload   (ev_release || ev_unfreeze),
        .uip         (uip),
        .sec_advance (sec_advance),
        .latch_time  (latch_time),
        .reload_time (reload_time)
    );

endmodule

// File: rtl/rtc_update_ctrl_chk.sv
module rtc_update_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       uip,
    input logic       sec_advance,
    input logic       latch_time,
    input logic       reload_time,
    input logic       run_q,
    input logic       freeze_q,
    input logic [2:0] div_q,
    input logic       uf_q
);

    // R2
    sec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sec_advance |=> !sec_advance);

    // R3
    frozen_chk: assert property (@(posedge clk) disable iff (rst)
        sec_advance |-> $past(run_q));

    // R4
    uip_fall_chk: assert property (@(posedge clk) disable iff (rst)
        sec_advance |-> ($past(uip) && !uip));

    // R5
    uip_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        freeze_q |-> !uip);

    // R5
    uip_divrst_chk: assert property (@(posedge clk) disable iff (rst)
        (div_q[2:1] == 2'b11) |-> !uip);

    // R6
    latch_uip_chk: assert property (@(posedge clk) disable iff (rst)
        latch_time |-> !uip);

    // R7
    reload_nowrap_chk: assert property (@(posedge clk) disable iff (rst)
        reload_time |-> !sec_advance);

    // R10
    uf_set_chk: assert property (@(posedge clk) disable iff (rst)
        sec_advance |-> uf_q);

endmodule

bind rtc_update_ctrl rtc_update_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .uip         (uip),
    .sec_advance (sec_advance),
    .latch_time  (latch_time),
    .reload_time (reload_time),
    .run_q       (run_q),
    .freeze_q    (freeze_q),
    .div_q       (div_q),
    .uf_q        (uf_q)
);

// File: tb/rtc_update_ctrl_test.sv
module rtc_update_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 1000;
    localparam int UIPT       = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        half_rate = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [23:0] time_now = 24'h000000;
    logic [23:0] alarm_cmp = 24'h123456;
    logic        uip, sec_advance, latch_time, reload_time;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rtc_update_ctrl #(
        .TICKS_PER_SEC (TPS),
        .UIP_TICKS     (UIPT),
        .TIME_W        (24)
    ) uut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .time_now    (time_now),
        .alarm_cmp   (alarm_cmp),
        .uip         (uip),
        .sec_advance (sec_advance),
        .latch_time  (latch_time),
        .reload_time (reload_time)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            if (half_rate) tick = ~tick;
            else           tick = 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1 v = rdata;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_pulse(input int limit, output int n, output int uhigh, output bit got);
        n = 0; uhigh = 0; got = 1'b0;
        while (n < limit) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (sec_advance) begin
                got = 1'b1;
                break;
            end
            if (uip) uhigh++;
        end
    endtask

    task automatic wait_uip(input int limit);
        for (int i = 0; i < limit && !uip; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic test_reset();
        logic [7:0] v;
        peek(2'd0, v); chk("R1 ctrl after reset", v, 8'h20);
        peek(2'd1, v); chk("R1 mode after reset", v, 8'h00);
        peek(2'd2, v); chk("R1 flags after reset", v, 8'h00);
        chk("R1 outputs after reset", {uip, sec_advance, latch_time, reload_time}, 0);
    endtask

    task automatic test_period();
        int n, uh; bit got;
        wait_pulse(2 * TPS, n, uh, got);
        chk("R2 first update seen", got, 1);
        chk("R2 first update delay", n, TPS);
        wait_pulse(2 * TPS, n, uh, got);
        chk("R2 update period", n, TPS);
        chk("R4 uip high cycles", uh, UIPT);
        chk("R4 uip low at update", uip, 0);
    endtask

    task automatic test_flags();
        logic [7:0] v;
        int n, uh; bit got;
        rd(2'd2, v);
        chk("R10 uf set after update", v, 8'h10);
        rd(2'd2, v);
        chk("R11 flags cleared by read", v, 8'h00);
        time_now = alarm_cmp;
        wait_pulse(2 * TPS, n, uh, got);
        time_now = 24'h000000;
        rd(2'd2, v);
        chk("R10 uf and af on alarm match", v, 8'h30);
        wait_pulse(2 * TPS, n, uh, got);
        rd(2'd2, v);
        chk("R10 no af without match", v, 8'h10);
    endtask

    task automatic test_read_race();
        logic [7:0] v;
        int n, uh; bit got;
        wait_pulse(2 * TPS, n, uh, got);
        rd(2'd2, v);
        repeat (TPS - 2) @(posedge clk);
        @(negedge clk);
        rd(2'd2, v);
        chk("R11 flags before race edge", v, 8'h00);
        chk("R11 update at read edge", sec_advance, 1);
        rd(2'd2, v);
        chk("R11 set wins over read clear", v, 8'h10);
    endtask

    task automatic test_ctrl_ro();
        logic [7:0] v;
        int n, uh; bit got;
        wait_uip(2 * TPS);
        wr(2'd0, 8'h2F);
        peek(2'd0, v);
        chk("R9 uip kept high on write", v, 8'hAF);
        wait_pulse(2 * TPS, n, uh, got);
        wr(2'd0, 8'hA0);
        peek(2'd0, v);
        chk("R9 uip bit not writable", v, 8'h20);
    endtask

    task automatic test_freeze();
        logic [7:0] v;
        int n, uh; bit got;
        rd(2'd2, v);
        wait_uip(2 * TPS);
        wr(2'd1, 8'h80);
        chk("R5 uip dropped by freeze", uip, 0);
        wait_pulse(3 * TPS / 2, n, uh, got);
        chk("R3 no update while frozen", got, 0);
        chk("R5 no uip while frozen", uh, 0);
        rd(2'd2, v);
        chk("R3 no uf while frozen", v, 8'h00);
        peek(2'd1, v);
        chk("R3 mode readback", v, 8'h80);
        wr(2'd1, 8'h00);
        chk("R8 reload pulse on unfreeze", reload_time, 1);
        wait_pulse(2 * TPS, n, uh, got);
        chk("R8 update one second after unfreeze", n, TPS);
        chk("R8 uip cycles after unfreeze", uh, UIPT);
    endtask

    task automatic test_other_div();
        logic [7:0] v;
        int n, uh; bit got;
        wr(2'd0, 8'h00);
        wait_pulse(3 * TPS / 2, n, uh, got);
        chk("R3 no update with divider 000", got, 0);
        chk("R5 no uip with divider 000", uh, 0);
        wr(2'd0, 8'h20);
        chk("R7 no reload from divider 000", reload_time, 0);
        wait_pulse(2 * TPS, n, uh, got);
        chk("R2 updates resume", got, 1);
        rd(2'd2, v);
    endtask

    task automatic test_divrst();
        logic [7:0] v;
        int n, uh; bit got;
        wait_uip(2 * TPS);
        wr(2'd0, 8'h60);
        chk("R6 latch pulse on divider hold", latch_time, 1);
        chk("R6 uip cleared on divider hold", uip, 0);
        wait_pulse(2 * TPS, n, uh, got);
        chk("R3 no update in divider hold", got, 0);
        chk("R5 no uip in divider hold", uh, 0);
        peek(2'd0, v);
        chk("R6 ctrl readback in hold", v, 8'h60);
        wr(2'd0, 8'h20);
        chk("R7 reload pulse on release", reload_time, 1);
        chk("R7 no latch on release", latch_time, 0);
        wait_pulse(2 * TPS, n, uh, got);
        chk("R7 first update half second after release", n, TPS / 2);
        chk("R7 uip cycles after release", uh, UIPT);
        wait_pulse(2 * TPS, n, uh, got);
        chk("R7 full second afterwards", n, TPS);
    endtask

    task automatic test_tick_rate();
        int n, uh; bit got;
        half_rate = 1'b1;
        wait_pulse(4 * TPS, n, uh, got);
        wait_pulse(4 * TPS, n, uh, got);
        chk("R12 period with half-rate tick", n, 2 * TPS);
        chk("R12 uip cycles with half-rate tick", uh, 2 * UIPT);
        half_rate = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_period();
        test_flags();
        test_read_race();
        test_ctrl_ro();
        test_freeze();
        test_other_div();
        test_divrst();
        test_tick_rate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule